// File: doc/BRIEF.md
# Idle and Sleep Power Mode Sequencer

This block runs the two deep power-saving states of a chip, on the crystal-domain clock. In the idle state it holds the CPU core clock enable low and leaves every peripheral clock alone. Any interrupt request returns the core clock. The idle control bit stays set until software writes it to zero. In the sleep state it drops the enable for the switchable core supply. Only configured external interrupt pins or the real-time alarm can bring it back, and a battery-fault pin can veto them. The way back is a full internal reset of fixed length, timed by a 16-bit counter.

Software writes the idle and sleep bits through a single write strobe. After the wake reset, software reads a status flag that separates a sleep wakeup from a power-on start. Pending bits name the unmasked pins that caused the wakeup. The low four pins report through one pending group and the upper twelve through another. A battery-function field decides whether the fault pin raises an interrupt or blocks wakeup. All wake-related pins pass through a two-flop synchronizer.

Top module: `pwr_mode_seq`

## Requirements
- R1: After power-on reset `cpu_clk_en_o`=1, `pwren_o`=1, `int_rst_no`=1, and `wake_flag_o`, `idle_bit_o`, `src_pend_o` and `ext_pend_o` are all 0.
- R2: A write (`ctl_wr_i`=1) with `ctl_idle_i`=1 and `ctl_sleep_i`=0 in the running state drives `cpu_clk_en_o` low from the next cycle, keeps `pwren_o` high, and sets `idle_bit_o`.
- R3: In idle, `irq_i`=1 sets `cpu_clk_en_o` high in the next cycle. `idle_bit_o` stays 1 until a later write with `ctl_idle_i`=0.
- R4: A write with `ctl_sleep_i`=1 in the running state drives `pwren_o` and `cpu_clk_en_o` low from the next cycle. Sleep wins when the idle bit is written at the same time.
- R5: In sleep, `irq_i` and any `eint_i` pin whose `eint_cfg_i` bit is 0 have no effect: `pwren_o` stays 0 and `int_rst_no` stays 1.
- R6: In sleep, a wake source (`eint_i[i]` with `eint_cfg_i[i]`=1, or `rtc_alarm_i`) driven before clock edge 1 causes no change after edge 2. After edge 3, `pwren_o`=1 and `int_rst_no`=0 together. The supply is therefore back before the reset is released.
- R7: `int_rst_no` stays low for exactly RST_CYCLES clock cycles (default 65535). When it releases, `cpu_clk_en_o` is 1.
- R8: `wake_flag_o` goes to 1 together with the wake reset and stays 1 through later sleep cycles until the next power-on reset.
- R9: With `batt_func_i[2:1]`=2'b11 and `batt_flt_ni` low, no wake source leaves sleep. When `batt_flt_ni` returns high, a wake source that is still active proceeds as in R6.
- R10: `batt_irq_o` is 1 when `batt_func_i[2:1]`=2'b10, the synchronized `batt_flt_ni` is low, and the block is not in sleep. It is 0 in sleep and for any other field value.
- R11: A wake from pin i with `eint_mask_i[i]`=0 sets `src_pend_o[i]` for i<4 and `ext_pend_o[i-4]` for i>=4. A pin with mask bit 1 still wakes the block but sets no pending bit. Pending bits clear only on power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal-domain clock |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low |
| ctl_wr_i | input | 1 | Strobe for a write to the control bits |
| ctl_idle_i | input | 1 | Idle bit value written |
| ctl_sleep_i | input | 1 | Sleep bit value written |
| irq_i | input | 1 | Interrupt request to the CPU |
| eint_i | input | 16 | External interrupt pins |
| eint_cfg_i | input | 16 | Pin configured as external interrupt |
| eint_mask_i | input | 16 | Pending mask per pin, 1 = masked |
| rtc_alarm_i | input | 1 | Real-time alarm wake source |
| batt_flt_ni | input | 1 | Battery fault, active low |
| batt_func_i | input | 3 | Battery function field |
| cpu_clk_en_o | output | 1 | CPU core clock enable |
| pwren_o | output | 1 | Switchable supply enable |
| int_rst_no | output | 1 | Internal reset, active low |
| wake_flag_o | output | 1 | Last reset came from a sleep wakeup |
| batt_irq_o | output | 1 | Battery fault interrupt |
| idle_bit_o | output | 1 | Read-back of the sticky idle bit |
| src_pend_o | output | 4 | Pending bits for pins 3..0 |
| ext_pend_o | output | 12 | Pending bits for pins 15..4 |

## Verification
The bench samples both sides of the wake point around the synchronizer delay. A design with one flop too few would leave sleep a cycle early. A design that drove the supply enable from the reset counter would show the reset low while the supply is still off. The bench counts the full reset pulse length, where an off-by-one timer is easy to see. It wakes on two pins that route to different pending groups at once, which catches swapped routing. A later wake on a masked pin must still wake the block and must leave the pending bits unchanged. It holds a configured pin active while the battery veto applies. A design that ignored the veto would leave sleep at once, and one that latched the veto would never leave at all.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_IDLE  = 2'd1,
    PM_SLEEP = 2'd2,
    PM_WAKE  = 2'd3
  } pm_state_e;
endpackage

// File: rtl/pms_sync.sv
module pms_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pms_wake.sv
module pms_wake #(
  parameter int unsigned N_EINT = 16,
  parameter int unsigned N_SRC  = 4,
  localparam int unsigned N_EXT = N_EINT - N_SRC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_sleep_i,
  input  logic              block_i,
  input  logic [N_EINT-1:0] eint_s_i,
  input  logic [N_EINT-1:0] cfg_i,
  input  logic [N_EINT-1:0] mask_i,
  input  logic              rtc_s_i,
  output logic              wake_o,
  output logic [N_SRC-1:0]  src_pend_o,
  output logic [N_EXT-1:0]  ext_pend_o
);
  logic [N_EINT-1:0] hit;
  logic [N_SRC-1:0]  src_d, src_q;
  logic [N_EXT-1:0]  ext_d, ext_q;

  assign hit    = eint_s_i & cfg_i;
  assign wake_o = in_sleep_i && !block_i && ((|hit) || rtc_s_i);

  for (genvar i = 0; i < N_EINT; i++) begin : g_route
    if (i < N_SRC) begin : g_src
      assign src_d[i] = src_q[i] | (wake_o & hit[i] & ~mask_i[i]);
    end else begin : g_ext
      assign ext_d[i-N_SRC] = ext_q[i-N_SRC] | (wake_o & hit[i] & ~mask_i[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
      ext_q <= '0;
    end else begin
      src_q <= src_d;
      ext_q <= ext_d;
    end
  end

  assign src_pend_o = src_q;
  assign ext_pend_o = ext_q;

  // R11
  pend_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(src_q) & ~src_q) == '0) && (($past(ext_q) & ~ext_q) == '0));

  // R11
  pend_only_on_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({src_q, ext_q} != $past({src_q, ext_q})) |-> $past(wake_o));
endmodule

// File: rtl/pms_rst_timer.sv
module pms_rst_timer #(
  parameter int unsigned CYCLES = 65535,
  localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic last_o
);
  logic [CNT_W-1:0] cnt_d, cnt_q;

  always_comb begin
    cnt_d = '0;
    if (run_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign last_o = run_i && (cnt_q == CNT_W'(CYCLES - 1));
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int unsigned N_EINT     = 16,
  parameter int unsigned N_SRC      = 4,
  parameter int unsigned RST_CYCLES = 65535,
  localparam int unsigned N_EXT = N_EINT - N_SRC,
  localparam int unsigned SYN_W = N_EINT + 2,
  localparam int unsigned LEN_W = $clog2(RST_CYCLES + 1) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_wr_i,
  input  logic              ctl_idle_i,
  input  logic              ctl_sleep_i,
  input  logic              irq_i,
  input  logic [N_EINT-1:0] eint_i,
  input  logic [N_EINT-1:0] eint_cfg_i,
  input  logic [N_EINT-1:0] eint_mask_i,
  input  logic              rtc_alarm_i,
  input  logic              batt_flt_ni,
  input  logic [2:0]        batt_func_i,
  output logic              cpu_clk_en_o,
  output logic              pwren_o,
  output logic              int_rst_no,
  output logic              wake_flag_o,
  output logic              batt_irq_o,
  output logic              idle_bit_o,
  output logic [N_SRC-1:0]  src_pend_o,
  output logic [N_EXT-1:0]  ext_pend_o
);
  pm_state_e state_d, state_q;
  logic idle_bit_d, idle_bit_q;
  logic wflag_d, wflag_q;
  logic [SYN_W-1:0] syn_q;
  logic [N_EINT-1:0] eint_s;
  logic rtc_s, flt_s, veto, wake, tmr_last;
  logic unused_func_lsb;

  assign unused_func_lsb = batt_func_i[0];

  pms_sync #(.W(SYN_W), .RST_VAL({1'b1, {(SYN_W-1){1'b0}}})) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({batt_flt_ni, rtc_alarm_i, eint_i}),
    .q_o   (syn_q)
  );

  assign eint_s = syn_q[N_EINT-1:0];
  assign rtc_s  = syn_q[N_EINT];
  assign flt_s  = syn_q[N_EINT+1];
  assign veto   = (batt_func_i[2:1] == 2'b11) && !flt_s;

  pms_wake #(.N_EINT(N_EINT), .N_SRC(N_SRC)) u_wake (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_sleep_i(state_q == PM_SLEEP),
    .block_i   (veto),
    .eint_s_i  (eint_s),
    .cfg_i     (eint_cfg_i),
    .mask_i    (eint_mask_i),
    .rtc_s_i   (rtc_s),
    .wake_o    (wake),
    .src_pend_o(src_pend_o),
    .ext_pend_o(ext_pend_o)
  );

  pms_rst_timer #(.CYCLES(RST_CYCLES)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (state_q == PM_WAKE),
    .last_o(tmr_last)
  );

  always_comb begin
    state_d    = state_q;
    idle_bit_d = idle_bit_q;
    wflag_d    = wflag_q;
    if (ctl_wr_i) idle_bit_d = ctl_idle_i;
    unique case (state_q)
      PM_RUN: begin
        if (ctl_wr_i && ctl_sleep_i)     state_d = PM_SLEEP;
        else if (ctl_wr_i && ctl_idle_i) state_d = PM_IDLE;
      end
      PM_IDLE:  if (irq_i) state_d = PM_RUN;
      PM_SLEEP: begin
        if (wake) begin
          state_d = PM_WAKE;
          wflag_d = 1'b1;
        end
      end
      PM_WAKE:  if (tmr_last) state_d = PM_RUN;
      default:  state_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= PM_RUN;
      idle_bit_q <= 1'b0;
      wflag_q    <= 1'b0;
    end else begin
      state_q    <= state_d;
      idle_bit_q <= idle_bit_d;
      wflag_q    <= wflag_d;
    end
  end

  assign cpu_clk_en_o = (state_q == PM_RUN);
  assign pwren_o      = (state_q != PM_SLEEP);
  assign int_rst_no   = (state_q != PM_WAKE);
  assign wake_flag_o  = wflag_q;
  assign idle_bit_o   = idle_bit_q;
  assign batt_irq_o   = (batt_func_i[2:1] == 2'b10) && !flt_s && (state_q != PM_SLEEP);

  logic [LEN_W-1:0] chk_len;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         chk_len <= '0;
    else if (!int_rst_no) chk_len <= chk_len + 1'b1;
    else                 chk_len <= '0;
  end

  // R2
  idle_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PM_RUN && ctl_wr_i && ctl_idle_i && !ctl_sleep_i)
      |=> (!cpu_clk_en_o && pwren_o && idle_bit_o));

  // R3
  idle_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PM_IDLE && irq_i) |=> cpu_clk_en_o);

  // R4
  sleep_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PM_RUN && ctl_wr_i && ctl_sleep_i) |=> (!pwren_o && !cpu_clk_en_o));

  // R6
  pwren_before_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwren_o) |-> !int_rst_no);

  // R7
  rst_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_rst_no) |-> (chk_len == LEN_W'(RST_CYCLES)));

  // R8
  wake_flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_flag_o |=> wake_flag_o);

  // R9
  batt_veto_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwren_o && batt_func_i[2:1] == 2'b11 && !flt_s) |=> !pwren_o);
endmodule

// File: tb/pwr_mode_seq_bench.sv
module pwr_mode_seq_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic ctl_wr, ctl_idle, ctl_sleep, irq;
  logic [15:0] eint, cfg, mask;
  logic rtc, flt_n;
  logic [2:0] func;
  logic cpu_en, pwren, irst_n, wflag, birq, ibit;
  logic [3:0] spend;
  logic [11:0] epend;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  typedef struct {
    string       tag;
    logic [31:0] val;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  pwr_mode_seq u_pwr_mode_seq (
    .clk_i(clk), .rst_ni(rst_n), .ctl_wr_i(ctl_wr), .ctl_idle_i(ctl_idle),
    .ctl_sleep_i(ctl_sleep), .irq_i(irq), .eint_i(eint), .eint_cfg_i(cfg),
    .eint_mask_i(mask), .rtc_alarm_i(rtc), .batt_flt_ni(flt_n), .batt_func_i(func),
    .cpu_clk_en_o(cpu_en), .pwren_o(pwren), .int_rst_no(irst_n), .wake_flag_o(wflag),
    .batt_irq_o(birq), .idle_bit_o(ibit), .src_pend_o(spend), .ext_pend_o(epend)
  );

  task automatic push_exp(string tag, logic [31:0] v);
    exp_t e;
    e.tag = tag;
    e.val = v;
    exp_q.push_back(e);
  endtask

  task automatic monitor(logic [31:0] act);
    exp_t e;
    e = exp_q.pop_front();
    compared++;
    if (act !== e.val) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", e.tag, act, e.val);
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] v);
    push_exp(tag, v);
    monitor(act);
  endtask

  task automatic wr(logic idle_v, logic sleep_v);
    ctl_wr = 1'b1; ctl_idle = idle_v; ctl_sleep = sleep_v;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_idle = 1'b0; ctl_sleep = 1'b0;
  endtask

  task automatic count_reset(string tag);
    int len = 1;
    while (irst_n == 1'b0 && len < 70000) begin
      @(negedge clk);
      if (irst_n == 1'b0) len++;
    end
    chk({tag, " reset length"}, len, 65535);
    chk({tag, " core clock after release"}, cpu_en, 1);
  endtask

  initial begin
    rst_n = 1'b0; ctl_wr = 0; ctl_idle = 0; ctl_sleep = 0; irq = 0;
    eint = '0; cfg = '0; mask = '0; rtc = 0; flt_n = 1'b1; func = 3'b000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cpu_clk_en", cpu_en, 1);
    chk("R1 pwren", pwren, 1);
    chk("R1 int_rst_n", irst_n, 1);
    chk("R1 wake_flag", wflag, 0);
    chk("R1 idle_bit", ibit, 0);
    chk("R1 pending", {spend, epend}, 0);

    // R2 enter idle
    wr(1'b1, 1'b0);
    chk("R2 core clock stopped", cpu_en, 0);
    chk("R2 supply kept", pwren, 1);
    chk("R2 idle bit", ibit, 1);
    repeat (3) @(negedge clk);
    chk("R2 idle holds", cpu_en, 0);

    // R3 interrupt leaves idle, bit stays
    irq = 1'b1;
    @(negedge clk);
    irq = 1'b0;
    chk("R3 core clock back", cpu_en, 1);
    chk("R3 idle bit sticky", ibit, 1);
    wr(1'b0, 1'b0);
    chk("R3 idle bit cleared by write", ibit, 0);

    // R10 battery interrupt
    func = 3'b101; flt_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 battery irq", birq, 1);
    func = 3'b000;
    @(negedge clk);
    chk("R10 battery irq other field", birq, 0);
    func = 3'b100;
    @(negedge clk);

    // R4 sleep wins over idle
    wr(1'b1, 1'b1);
    chk("R4 supply off", pwren, 0);
    chk("R4 core clock off", cpu_en, 0);
    chk("R10 no battery irq in sleep", birq, 0);

    // R5 non-wake stimuli
    irq = 1'b1; eint[5] = 1'b1;
    repeat (6) @(negedge clk);
    chk("R5 supply still off", pwren, 0);
    chk("R5 no reset", irst_n, 1);
    irq = 1'b0; eint[5] = 1'b0;

    // R9 battery veto, pins 2 and 6 configured and unmasked
    func = 3'b110;
    cfg = 16'h0244; mask = 16'h0200;
    eint[2] = 1'b1; eint[6] = 1'b1;
    repeat (6) @(negedge clk);
    chk("R9 veto holds sleep", pwren, 0);
    flt_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 not yet after two edges", pwren, 0);
    @(negedge clk);
    chk("R6 supply back", pwren, 1);
    chk("R6 reset asserted", irst_n, 0);
    chk("R8 wake flag set", wflag, 1);
    chk("R11 low group pending", spend, 4'b0100);
    chk("R11 high group pending", epend, 12'h004);
    eint = '0;
    count_reset("R7 first");

    // R11 masked pin still wakes, no pending change
    wr(1'b0, 1'b1);
    chk("R4 second sleep", pwren, 0);
    eint[9] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 masked pin wakes", irst_n, 0);
    chk("R11 low group unchanged", spend, 4'b0100);
    chk("R11 high group unchanged", epend, 12'h004);
    eint = '0;
    count_reset("R7 second");
    chk("R8 wake flag kept", wflag, 1);

    // R8 power-on reset clears flag
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 flag cleared by power-on", wflag, 0);
    chk("R1 pending cleared", {spend, epend}, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule